// File: doc/BRIEF.md
# Cyclic Drawing Window Address Stepper

This block turns a rectangular destination window, given in drawing coordinates, into the sequence of display memory addresses of its pels. The caller supplies a 13-bit origin on each axis, two sign-magnitude extents, a destination bank and a pel-size flag, and then pulses a start. The block walks the window row by row. For each pel it presents a bank, an 11-bit Y row, a byte column and a bit index within that byte. A downstream memory sequencer takes the pels through a valid/ready handshake.

Drawing coordinates live in a 13-bit space that wraps on both axes. Only the low 11 bits of each coordinate reach memory, so the larger cyclic space is folded onto the 2048 x 2048 memory plane. The extents can be given either as two full sign-magnitude words or as a single packed byte that holds a short signed step for each axis. When long pels are in use, a start that names an odd bank is refused. No pel is produced for it.

Top module: `win_addr_stepper`

## Requirements
- R1: After a synchronous active-low reset, pel_valid_o, done_o and err_o are all low.
- R2: A start accepted while idle makes pel_valid_o high in the next cycle. The first pel is the origin: pel_y_o = Yd[10:0], pel_col_o = Xd[10:3], pel_bit_o = Xd[2:0].
- R3: The scan is row-major. X moves by one pel per accepted pel, in the direction of its sign bit (0 = increasing, 1 = decreasing), for |DX|+1 pels per row. X then returns to Xd and Y moves by one in its own sign direction. There are |DY|+1 rows in all.
- R4: Coordinates wrap modulo 8192 on each axis, and memory addresses are the low 11 bits of the coordinate. Stepping below 0 gives 8191, which maps to column 255, bit 7. Stepping past 2047 gives memory address 0.
- R5: A full extent input is 12 bits: bit 11 is the sign and bits 10:0 are the magnitude. With short_sel_i high, the full extents are ignored and short_dim_i is used instead: bit 7 is the Y sign, bits 6:4 are |DY|, bit 3 is the X sign and bits 2:0 are |DX|.
- R6: A pel is consumed only in a cycle where pel_valid_o and pel_ready_i are both high. While ready is low, the presented pel and its address stay unchanged.
- R7: done_o is high for exactly one cycle: the cycle after the final pel is consumed. pel_valid_o is low in that cycle.
- R8: A start with long_pel_i high and bank_i[0] high raises err_o for one cycle in the next cycle. No pel is emitted and the block stays idle. An even bank with long pels runs normally.
- R9: A start pulse, and any change on the origin, extent or bank inputs, while a window is being walked has no effect on the pels of that window.
- R10: pel_bank_o holds the bank captured at start for every pel of the window.
- R11: A start presented in the same cycle as done_o is accepted, and the new window's first pel appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to walk a new window (sampled while idle) |
| long_pel_i | input | 1 | 1 = long pels, which require an even bank |
| bank_i | input | 2 | Destination bank |
| org_x_i | input | 13 | Window origin X in drawing coordinates |
| org_y_i | input | 13 | Window origin Y in drawing coordinates |
| dim_x_i | input | 12 | Full X extent: sign in bit 11, magnitude in 10:0 |
| dim_y_i | input | 12 | Full Y extent: sign in bit 11, magnitude in 10:0 |
| short_sel_i | input | 1 | 1 = take the extents from short_dim_i |
| short_dim_i | input | 8 | Packed short extents (layout in R5) |
| pel_ready_i | input | 1 | Consumer can take the presented pel |
| pel_valid_o | output | 1 | A pel address is presented |
| pel_bank_o | output | 2 | Bank of the presented pel |
| pel_y_o | output | 11 | Memory row of the presented pel |
| pel_col_o | output | 8 | Byte column (X without its 3 low bits) |
| pel_bit_o | output | 3 | Bit index within the byte (X low bits) |
| done_o | output | 1 | One-cycle pulse after the last pel |
| err_o | output | 1 | One-cycle pulse for a refused odd-bank long-pel start |

## Verification
The end-of-window pulse and the acceptance of the next window's start can fall in the same cycle, because the controller is already idle while done_o is high. The bench provokes this by driving start in exactly the done cycle, both for single-pel windows and after longer random walks. It judges the result by requiring done_o in that cycle and the new origin on the very next cycle, with no gap and no lost pulse. The bench also injects start pulses and scrambled origin and extent inputs mid-walk while ready toggles at random. Every consumed pel must still match the address computed from the captured window.

// File: rtl/wstep_pkg.sv
// Package: shared types and default widths for the window address stepper.
// Assumes: nothing; pure type and constant definitions.
package wstep_pkg;

    // Default widths of the drawing and memory spaces.
    localparam int DEF_COORD_W = 13;
    localparam int DEF_MEM_W   = 11;
    localparam int DEF_SEL_W   = 3;
    localparam int DEF_SHORT_W = 3;
    localparam int DEF_BANK_W  = 2;

    // Controller state: waiting for a start, or walking a window.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wstep_state_e;

endpackage

// File: rtl/wstep_dim_sel.sv
// Module: wstep_dim_sel
// Picks the window extents from either the full sign-magnitude inputs or
// the packed short byte, and returns a sign and a zero-extended magnitude
// per axis.
// Assumes: the short byte packs {ysign, |dy|, xsign, |dx|} from MSB to LSB,
// and SHORT_W < MAG_W.
module wstep_dim_sel #(
    parameter int MAG_W   = 11,
    parameter int SHORT_W = 3,
    localparam int SDIM_W = 2 * SHORT_W + 2
) (
    input  logic               short_sel_i,
    input  logic [MAG_W:0]     dim_x_i,
    input  logic [MAG_W:0]     dim_y_i,
    input  logic [SDIM_W-1:0]  short_dim_i,
    output logic               neg_x_o,
    output logic [MAG_W-1:0]   mag_x_o,
    output logic               neg_y_o,
    output logic [MAG_W-1:0]   mag_y_o
);

    localparam int PAD_W = MAG_W - SHORT_W;

    logic [SHORT_W-1:0] s_mag_x;
    logic [SHORT_W-1:0] s_mag_y;
    logic               s_neg_x;
    logic               s_neg_y;

    // Split the packed short byte into its two signed fields.
    always_comb begin
        s_mag_x = short_dim_i[SHORT_W-1:0];
        s_neg_x = short_dim_i[SHORT_W];
        s_mag_y = short_dim_i[2*SHORT_W:SHORT_W+1];
        s_neg_y = short_dim_i[SDIM_W-1];
    end

    // Select between the short and the full extent encodings.
    always_comb begin
        if (short_sel_i) begin
            neg_x_o = s_neg_x;
            mag_x_o = {{PAD_W{1'b0}}, s_mag_x};
            neg_y_o = s_neg_y;
            mag_y_o = {{PAD_W{1'b0}}, s_mag_y};
        end else begin
            neg_x_o = dim_x_i[MAG_W];
            mag_x_o = dim_x_i[MAG_W-1:0];
            neg_y_o = dim_y_i[MAG_W];
            mag_y_o = dim_y_i[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/wstep_axis.sv
// Module: wstep_axis
// One axis of the walk. It holds a cyclic coordinate of COORD_W bits and a
// count of pels taken on this axis. On load it returns to the origin. On
// step it moves one unit in the captured direction, or returns to the
// origin when the count has reached the magnitude. It exposes the
// coordinate folded to MEM_W bits.
// Assumes: MEM_W <= COORD_W; load and step are never high together.
module wstep_axis #(
    parameter int COORD_W = 13,
    parameter int MEM_W   = 11,
    parameter int MAG_W   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [COORD_W-1:0] org_i,
    input  logic               neg_i,
    input  logic [MAG_W-1:0]   mag_i,
    output logic [MEM_W-1:0]   mem_o,
    output logic               last_o
);

    logic [COORD_W-1:0] coord_q;
    logic [COORD_W-1:0] origin_q;
    logic               neg_q;
    logic [MAG_W-1:0]   mag_q;
    logic [MAG_W-1:0]   cnt_q;
    logic [COORD_W-1:0] coord_adj;

    // Neighbouring coordinate in the captured direction, modulo 2^COORD_W.
    always_comb begin
        if (neg_q) coord_adj = coord_q - COORD_W'(1);
        else       coord_adj = coord_q + COORD_W'(1);
    end

    // Capture the window geometry for this axis at load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            origin_q <= '0;
            neg_q    <= 1'b0;
            mag_q    <= '0;
        end else if (load_i) begin
            origin_q <= org_i;
            neg_q    <= neg_i;
            mag_q    <= mag_i;
        end
    end

    // Advance the coordinate and the pel count on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coord_q <= '0;
            cnt_q   <= '0;
        end else if (load_i) begin
            coord_q <= org_i;
            cnt_q   <= '0;
        end else if (step_i) begin
            if (last_o) begin
                coord_q <= origin_q;
                cnt_q   <= '0;
            end else begin
                coord_q <= coord_adj;
                cnt_q   <= cnt_q + MAG_W'(1);
            end
        end
    end

    assign last_o = (cnt_q == mag_q);
    assign mem_o  = coord_q[MEM_W-1:0];

endmodule

// File: rtl/wstep_ctrl.sv
// Module: wstep_ctrl
// Sequencer for the walk. While idle it accepts a start. It refuses, with
// a one-cycle error pulse, a long-pel start aimed at an odd bank. When the
// final pel is consumed it returns to idle with a one-cycle done pulse.
// Assumes: final_i is high only while the last pel of the window is
// presented.
module wstep_ctrl
    import wstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic long_pel_i,
    input  logic bank_odd_i,
    input  logic fire_i,
    input  logic final_i,
    output logic load_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);

    wstep_state_e state_q;
    logic         refuse;

    // Decode an acceptable start and a refused one while idle.
    always_comb begin
        refuse = (state_q == ST_IDLE) && start_i && long_pel_i && bank_odd_i;
        load_o = (state_q == ST_IDLE) && start_i && !refuse;
    end

    // State register: enter the walk on load, leave it after the last pel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (load_o)             state_q <= ST_RUN;
                ST_RUN:  if (fire_i && final_i)  state_q <= ST_IDLE;
                default:                         state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle pulses for window completion and refused starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            done_o <= (state_q == ST_RUN) && fire_i && final_i;
            err_o  <= refuse;
        end
    end

    assign busy_o = (state_q == ST_RUN);

endmodule

// File: rtl/wstep_map.sv
// Module: wstep_map
// Splits a folded X memory address into a byte column and a bit index, and
// passes the folded Y row through.
// Assumes: each bit plane is organised in bytes of 2^SEL_W bits.
module wstep_map #(
    parameter int MEM_W = 11,
    parameter int SEL_W = 3,
    localparam int COL_W = MEM_W - SEL_W
) (
    input  logic [MEM_W-1:0] x_mem_i,
    input  logic [MEM_W-1:0] y_mem_i,
    output logic [MEM_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic [SEL_W-1:0] bit_o
);

    // Byte column from the high part of X, bit select from its low part.
    always_comb begin
        row_o = y_mem_i;
        col_o = x_mem_i[MEM_W-1:SEL_W];
        bit_o = x_mem_i[SEL_W-1:0];
    end

endmodule

// File: rtl/win_addr_stepper.sv
// Module: win_addr_stepper
// Walks every pel of a rectangular window in a cyclic drawing space, row
// by row. It presents the display memory address of each pel (bank, row,
// byte column, bit index) through a valid/ready handshake.
// Assumes: start is sampled only while idle; the consumer may hold ready
// low for any number of cycles.
module win_addr_stepper
    import wstep_pkg::*;
#(
    parameter int COORD_W = DEF_COORD_W,
    parameter int MEM_W   = DEF_MEM_W,
    parameter int SEL_W   = DEF_SEL_W,
    parameter int SHORT_W = DEF_SHORT_W,
    parameter int BANK_W  = DEF_BANK_W,
    localparam int COL_W  = MEM_W - SEL_W,
    localparam int MAG_W  = MEM_W,
    localparam int SDIM_W = 2 * SHORT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               long_pel_i,
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [COORD_W-1:0] org_x_i,
    input  logic [COORD_W-1:0] org_y_i,
    input  logic [MAG_W:0]     dim_x_i,
    input  logic [MAG_W:0]     dim_y_i,
    input  logic               short_sel_i,
    input  logic [SDIM_W-1:0]  short_dim_i,
    input  logic               pel_ready_i,
    output logic               pel_valid_o,
    output logic [BANK_W-1:0]  pel_bank_o,
    output logic [MEM_W-1:0]   pel_y_o,
    output logic [COL_W-1:0]   pel_col_o,
    output logic [SEL_W-1:0]   pel_bit_o,
    output logic               done_o,
    output logic               err_o
);

    localparam int AXES = 2;

    logic                 load;
    logic                 busy;
    logic                 fire;
    logic                 final_pel;
    logic [BANK_W-1:0]    bank_q;

    logic [AXES-1:0]      neg_ax;
    logic [MAG_W-1:0]     mag_ax  [AXES];
    logic [COORD_W-1:0]   org_ax  [AXES];
    logic [MEM_W-1:0]     mem_ax  [AXES];
    logic [AXES-1:0]      step_ax;
    logic [AXES-1:0]      last_ax;

    // Extent decode: full sign-magnitude words or the packed short byte.
    wstep_dim_sel #(
        .MAG_W   (MAG_W),
        .SHORT_W (SHORT_W)
    ) u_dim (
        .short_sel_i (short_sel_i),
        .dim_x_i     (dim_x_i),
        .dim_y_i     (dim_y_i),
        .short_dim_i (short_dim_i),
        .neg_x_o     (neg_ax[0]),
        .mag_x_o     (mag_ax[0]),
        .neg_y_o     (neg_ax[1]),
        .mag_y_o     (mag_ax[1])
    );

    // Route the origins and the step enables to the axes: X steps on every
    // consumed pel, Y only when X closes a row.
    always_comb begin
        org_ax[0]  = org_x_i;
        org_ax[1]  = org_y_i;
        fire       = busy && pel_ready_i;
        step_ax[0] = fire;
        step_ax[1] = fire && last_ax[0];
        final_pel  = &last_ax;
    end

    // One stepper per axis.
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        wstep_axis #(
            .COORD_W (COORD_W),
            .MEM_W   (MEM_W),
            .MAG_W   (MAG_W)
        ) u_axis (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .step_i (step_ax[a]),
            .org_i  (org_ax[a]),
            .neg_i  (neg_ax[a]),
            .mag_i  (mag_ax[a]),
            .mem_o  (mem_ax[a]),
            .last_o (last_ax[a])
        );
    end

    // Walk sequencer with the odd-bank check for long pels.
    wstep_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .long_pel_i (long_pel_i),
        .bank_odd_i (bank_i[0]),
        .fire_i     (fire),
        .final_i    (final_pel),
        .load_o     (load),
        .busy_o     (busy),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    // Capture the destination bank for the whole window.
    always_ff @(posedge clk) begin
        if (!rst_n)    bank_q <= '0;
        else if (load) bank_q <= bank_i;
    end

    // Folded coordinates to row, byte column and bit index.
    wstep_map #(
        .MEM_W (MEM_W),
        .SEL_W (SEL_W)
    ) u_map (
        .x_mem_i (mem_ax[0]),
        .y_mem_i (mem_ax[1]),
        .row_o   (pel_y_o),
        .col_o   (pel_col_o),
        .bit_o   (pel_bit_o)
    );

    assign pel_valid_o = busy;
    assign pel_bank_o  = bank_q;

endmodule

// File: rtl/wstep_chk.sv
// Module: wstep_chk
// Protocol checker for win_addr_stepper, attached with bind.
// Assumes: the reset is synchronous and active low.
module wstep_chk #(
    parameter int MEM_W  = 11,
    parameter int SEL_W  = 3,
    parameter int BANK_W = 2,
    localparam int COL_W = MEM_W - SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pel_valid_o,
    input logic              pel_ready_i,
    input logic [BANK_W-1:0] pel_bank_o,
    input logic [MEM_W-1:0]  pel_y_o,
    input logic [COL_W-1:0]  pel_col_o,
    input logic [SEL_W-1:0]  pel_bit_o,
    input logic              done_o,
    input logic              err_o
);

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        pel_valid_o && !pel_ready_i |=> pel_valid_o && $stable(pel_y_o) && $stable(pel_col_o) && $stable(pel_bit_o)); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pel_valid_o && $past(pel_valid_o && pel_ready_i)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_ERR_NO_PEL: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !pel_valid_o && !done_o); // R8

    AST_BANK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        pel_valid_o |=> !pel_valid_o || $stable(pel_bank_o)); // R10

endmodule

bind win_addr_stepper wstep_chk #(
    .MEM_W  (MEM_W),
    .SEL_W  (SEL_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pel_valid_o (pel_valid_o),
    .pel_ready_i (pel_ready_i),
    .pel_bank_o  (pel_bank_o),
    .pel_y_o     (pel_y_o),
    .pel_col_o   (pel_col_o),
    .pel_bit_o   (pel_bit_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_win_addr_stepper.sv
// Bench for win_addr_stepper: directed corner windows plus seeded random
// windows, each pel checked against an address computed from the captured
// window geometry.
module tb_win_addr_stepper;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        long_pel_i;
    logic [1:0]  bank_i;
    logic [12:0] org_x_i;
    logic [12:0] org_y_i;
    logic [11:0] dim_x_i;
    logic [11:0] dim_y_i;
    logic        short_sel_i;
    logic [7:0]  short_dim_i;
    logic        pel_ready_i;
    logic        pel_valid_o;
    logic [1:0]  pel_bank_o;
    logic [10:0] pel_y_o;
    logic [7:0]  pel_col_o;
    logic [2:0]  pel_bit_o;
    logic        done_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;

    // Captured window as the bench understands it.
    logic [12:0] jx, jy;
    bit          jsx, jsy;
    int          jmx, jmy;
    logic [1:0]  jbank;

    win_addr_stepper dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .long_pel_i  (long_pel_i),
        .bank_i      (bank_i),
        .org_x_i     (org_x_i),
        .org_y_i     (org_y_i),
        .dim_x_i     (dim_x_i),
        .dim_y_i     (dim_y_i),
        .short_sel_i (short_sel_i),
        .short_dim_i (short_dim_i),
        .pel_ready_i (pel_ready_i),
        .pel_valid_o (pel_valid_o),
        .pel_bank_o  (pel_bank_o),
        .pel_y_o     (pel_y_o),
        .pel_col_o   (pel_col_o),
        .pel_bit_o   (pel_bit_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Expected cyclic X coordinate of pel number idx (R3, R4).
    function automatic logic [12:0] exp_x(input int idx);
        int c = idx % (jmx + 1);
        return jsx ? jx - 13'(c) : jx + 13'(c);
    endfunction

    // Expected cyclic Y coordinate of pel number idx (R3, R4).
    function automatic logic [12:0] exp_y(input int idx);
        int r = idx / (jmx + 1);
        return jsy ? jy - 13'(r) : jy + 13'(r);
    endfunction

    // Drive a start at a negative edge; returns one negative edge later.
    task automatic launch(input logic [12:0] x, input logic [12:0] y,
                          input bit sx, input int mx, input bit sy, input int my,
                          input logic [1:0] bank, input bit lng,
                          input bit sh, input logic [7:0] sb);
        org_x_i = x; org_y_i = y; bank_i = bank; long_pel_i = lng;
        short_sel_i = sh; short_dim_i = sb;
        jx = x; jy = y; jbank = bank;
        if (sh) begin
            // R5 short layout: [7] y sign, [6:4] |dy|, [3] x sign, [2:0] |dx|
            jsy = sb[7]; jmy = int'(sb[6:4]); jsx = sb[3]; jmx = int'(sb[2:0]);
            dim_x_i = 12'($urandom); dim_y_i = 12'($urandom);
        end else begin
            jsx = sx; jmx = mx; jsy = sy; jmy = my;
            dim_x_i = {sx, 11'(mx)}; dim_y_i = {sy, 11'(my)};
        end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(pel_valid_o === 1'b1,
            $sformatf("R2 valid after start got=%b exp=1", pel_valid_o));
    endtask

    // Consume the whole window; optionally poke start and inputs (R9).
    task automatic consume(input int ready_pct, input bit poke, input string tag);
        int total = (jmx + 1) * (jmy + 1);
        int idx = 0;
        int guard = 0;
        while (idx < total && guard < 40000) begin
            guard++;
            if (pel_valid_o !== 1'b1) begin
                chk(1'b0, $sformatf("R6 valid dropped at pel %0d got=%b exp=1", idx, pel_valid_o));
                break;
            end
            if (pel_ready_i) begin
                logic [12:0] ex = exp_x(idx);
                logic [12:0] ey = exp_y(idx);
                chk(pel_y_o === ey[10:0] && pel_col_o === ex[10:3] &&
                    pel_bit_o === ex[2:0] && pel_bank_o === jbank,
                    $sformatf("%s R10 pel %0d got y=%h col=%h bit=%h bank=%h exp y=%h col=%h bit=%h bank=%h",
                              tag, idx, pel_y_o, pel_col_o, pel_bit_o, pel_bank_o,
                              ey[10:0], ex[10:3], ex[2:0], jbank));
                idx++;
            end
            if (idx < total) begin
                pel_ready_i = (($urandom % 100) < ready_pct);
                start_i = poke && (($urandom % 4) == 0);
                if (start_i) begin
                    org_x_i = 13'($urandom); org_y_i = 13'($urandom);
                    dim_x_i = 12'($urandom); dim_y_i = 12'($urandom);
                    bank_i = 2'($urandom); short_sel_i = 1'($urandom);
                end
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        chk(done_o === 1'b1 && pel_valid_o === 1'b0,
            $sformatf("R7 %s end got done=%b valid=%b exp done=1 valid=0", tag, done_o, pel_valid_o));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start_i = 1'b0; long_pel_i = 1'b0; bank_i = '0;
        org_x_i = '0; org_y_i = '0; dim_x_i = '0; dim_y_i = '0;
        short_sel_i = 1'b0; short_dim_i = '0; pel_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pel_valid_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0,
            $sformatf("R1 reset got valid=%b done=%b err=%b exp 0 0 0", pel_valid_o, done_o, err_o));

        // R4: negative walk from the origin wraps to 8191 on both axes.
        launch(13'd0, 13'd0, 1'b1, 3, 1'b1, 2, 2'd1, 1'b0, 1'b0, 8'h00);
        consume(100, 1'b0, "R4 wrap below zero");
        // R4: positive walk through 8191 back to 0.
        @(negedge clk);
        launch(13'd8190, 13'd8191, 1'b0, 4, 1'b0, 1, 2'd2, 1'b0, 1'b0, 8'h00);
        consume(60, 1'b0, "R4 wrap past top");
        // R4: coordinate 2048 folds onto memory address 0.
        @(negedge clk);
        launch(13'd2045, 13'd2047, 1'b0, 5, 1'b0, 2, 2'd3, 1'b0, 1'b0, 8'h00);
        consume(100, 1'b0, "R4 fold at 2048");
        // R3: widest row with one row.
        @(negedge clk);
        launch(13'd100, 13'd5, 1'b0, 2047, 1'b0, 0, 2'd0, 1'b0, 1'b0, 8'h00);
        consume(100, 1'b0, "R3 full row");
        // R5: short byte, dy negative 2, dx positive 5; full extents garbage.
        @(negedge clk);
        launch(13'd40, 13'd300, 1'b0, 0, 1'b0, 0, 2'd1, 1'b0, 1'b1, 8'b1010_0101);
        consume(80, 1'b0, "R5 short dims");

        // R8: long pels with odd bank are refused.
        @(negedge clk);
        long_pel_i = 1'b1; bank_i = 2'd3; short_sel_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o === 1'b1 && pel_valid_o === 1'b0,
            $sformatf("R8 refuse got err=%b valid=%b exp err=1 valid=0", err_o, pel_valid_o));
        @(negedge clk);
        chk(err_o === 1'b0 && pel_valid_o === 1'b0,
            $sformatf("R8 after refuse got err=%b valid=%b exp 0 0", err_o, pel_valid_o));
        // R8: long pels with an even bank run normally.
        launch(13'd7, 13'd9, 1'b1, 2, 1'b0, 1, 2'd2, 1'b1, 1'b0, 8'h00);
        chk(err_o === 1'b0, $sformatf("R8 even bank err got=%b exp=0", err_o));
        consume(100, 1'b0, "R8 even long");

        // R11: single-pel windows back to back, start in the done cycle.
        launch(13'd17, 13'd33, 1'b0, 0, 1'b0, 0, 2'd1, 1'b0, 1'b0, 8'h00);
        consume(100, 1'b0, "R11 first");
        launch(13'd18, 13'd34, 1'b0, 0, 1'b0, 0, 2'd2, 1'b0, 1'b0, 8'h00);
        consume(100, 1'b0, "R11 second");

        // R9: random windows with stalls and pokes mid-walk, chained so some
        // starts land in the done cycle (R11).
        for (int j = 0; j < 30; j++) begin
            bit lng = 1'($urandom);
            logic [1:0] bk = 2'($urandom);
            if (lng) bk[0] = 1'b0;
            launch(13'($urandom), 13'($urandom), 1'($urandom), int'($urandom % 13),
                   1'($urandom), int'($urandom % 9), bk, lng,
                   (($urandom % 4) == 0), 8'($urandom));
            consume(((j % 2) == 0) ? 70 : 100, 1'b1, "R9 random");
            if ((j % 3) == 0) @(negedge clk);
        end

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule